// File: doc/BRIEF.md
# DMA-Filled Word Mailbox

This block is a small mailbox that sits between a local processor and a DMA engine. The processor starts a transfer by writing a byte count to the count register. The mailbox then raises its DMA request and shows itself busy. While the DMA engine holds its active-low acknowledge, it pushes 16-bit words into a nine-word buffer, one word per write transaction. When the programmed number of words has arrived, the request drops, busy clears, and an interrupt is raised unless it is masked. The processor then reads the words back through addressed registers.

Data is packed low byte first. A byte count of n becomes ceil(n/2) word transactions. When n is odd, the last word carries the final byte in its low half, and the mailbox stores zero in the unused high half.

The control is a two-state machine. ST_IDLE leaves on the START transition, which is a legal count write, and enters ST_XFER. ST_XFER returns on the FINISH transition, which is the accepted DMA write that brings the remaining count from 1 to 0. No other transitions exist.

Top module: `dma_fill_mailbox`

## Requirements
- R1: After reset, dma_req and irq are 0. The status register (address 10) reads 0, the count register (address 9) reads 0, and every buffer word reads 0.
- R2: A processor write to address 9 with a value n, where 1 <= n <= 18, made while idle, raises dma_req from the next cycle. It also sets busy (status bit 2), and the count register reads ceil(n/2) in bits 12:8 (total) and in bits 4:0 (remaining).
- R3: A DMA write is accepted when dma_wr is 1 and dma_ack_n is 0 during a transfer. Each accepted write decrements the remaining count by one and stores its word at buffer index total minus remaining, so words fill in ascending order from index 0.
- R4: In the cycle after the accepted write that brings the remaining count to 0, dma_req and busy are 0.
- R5: On completion with the mask bit (status bit 0) at 0, irq and status bit 1 become 1. They stay 1 until the processor writes 1 to bit 1 of address 10 or writes a legal count.
- R6: With the mask bit at 1 when the transfer completes, irq stays 0.
- R7: A count write of 0 is ignored: busy and dma_req stay 0.
- R8: A count write made while busy is ignored: the total and remaining counts are unchanged.
- R9: A count write greater than 18 is ignored, and the count register keeps its previous value.
- R10: When the byte count is odd, the last stored word has its high byte (bits 15:8) forced to 0 and keeps the DMA data in bits 7:0.
- R11: DMA writes with dma_ack_n at 1, or made while idle, are discarded: the buffer and the counts are unchanged.
- R12: Reads are combinational. Addresses 0 to 8 return buffer words, 9 returns the count register, 10 returns {busy, irq, mask} in bits 2:0, and any other address returns 0. Writing address 10 sets the mask from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_addr | input | 4 | Processor register address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Processor read data for cpu_addr |
| dma_req | output | 1 | DMA request, high while a transfer is pending |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| dma_wr | input | 1 | DMA write transaction strobe |
| dma_wdata | input | 16 | DMA write word |
| irq | output | 1 | Completion interrupt, level |

## Verification
The transfer path is run with an odd count that includes an acknowledge-high stall, with a full 18-byte count followed by overrun writes, and with a one-word even count. Together these separate the ordering of the write index, the masking of the high byte on the last word, and the discarding of writes after completion. Count writes of zero, of more than 18, and made while busy are mixed in, so a design that loads on any write is caught. A behavioural model built from queues and integers is compared with the request, the interrupt and the addressed read data on every clock. This exposes any difference in the cycle where the request drops or the interrupt rises.

// File: rtl/dfm_pkg.sv
package dfm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } dfm_state_e;
endpackage

// File: rtl/dfm_wordbuf.sv
module dfm_wordbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 9,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic              clr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] words [DEPTH];
    logic [DATA_W-1:0] wr_word;

    assign wr_word = clr_hi ? {{HALF{1'b0}}, wdata[HALF-1:0]} : wdata;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (we && wr_idx == CNT_W'(g))
                words[g] <= wr_word;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (rd_idx == CNT_W'(i))
                rd_data = words[i];
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> wr_idx < CNT_W'(DEPTH)); // R3
endmodule

// File: rtl/dfm_ctrl.sv
module dfm_ctrl
    import dfm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 9,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] cnt_bytes,
    input  logic              ctl_wr,
    input  logic              ctl_mask,
    input  logic              ctl_clr,
    input  logic              dma_wr,
    input  logic              dma_ack_n,
    output logic              busy,
    output logic              irq,
    output logic              mask,
    output logic [CNT_W-1:0]  rem,
    output logic [CNT_W-1:0]  total,
    output logic              buf_we,
    output logic [CNT_W-1:0]  buf_idx,
    output logic              buf_clr_hi
);
    localparam int MAX_BYTES = 2 * DEPTH;

    dfm_state_e state_q, state_d;
    logic [CNT_W-1:0] rem_q, total_q, words;
    logic odd_q, mask_q, irq_q;
    logic start, accept, finish;

    assign words  = CNT_W'((cnt_bytes + DATA_W'(1)) >> 1);
    assign start  = cnt_wr && state_q == ST_IDLE && cnt_bytes != '0
                    && cnt_bytes <= DATA_W'(MAX_BYTES);
    assign accept = state_q == ST_XFER && dma_wr && !dma_ack_n;
    assign finish = accept && rem_q == CNT_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)  state_d = ST_XFER;
            ST_XFER: if (finish) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            total_q <= '0;
            odd_q   <= 1'b0;
            mask_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (start) begin
                rem_q   <= words;
                total_q <= words;
                odd_q   <= cnt_bytes[0];
            end else if (accept) begin
                rem_q   <= rem_q - CNT_W'(1);
            end
            if (ctl_wr)
                mask_q <= ctl_mask;
            if (finish && !mask_q)
                irq_q <= 1'b1;
            else if (start || (ctl_wr && ctl_clr))
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        busy       = state_q == ST_XFER;
        irq        = irq_q;
        mask       = mask_q;
        rem        = rem_q;
        total      = total_q;
        buf_we     = accept;
        buf_idx    = total_q - rem_q;
        buf_clr_hi = finish && odd_q;
    end

    AST_START_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && rem_q != '0); // R2
    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !finish) |=> rem_q == $past(rem_q) - CNT_W'(1)); // R3
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= total_q); // R3
    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy && rem_q == '0); // R4
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !mask_q) |=> irq_q); // R5
    AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && mask_q) |=> !irq_q); // R6
    AST_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cnt_wr && cnt_bytes == '0) |=> !busy); // R7
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_wr && !accept) |=> $stable(rem_q) && $stable(total_q)); // R8
    AST_IDLE_DMA_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cnt_wr) |=> $stable(rem_q)); // R11
endmodule

// File: rtl/dma_fill_mailbox.sv
module dma_fill_mailbox #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 9,
    parameter int CNT_W  = 5,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              dma_req,
    input  logic              dma_ack_n,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic              irq
);
    localparam int ADDR_CNT = DEPTH;
    localparam int ADDR_CTL = DEPTH + 1;

    logic busy, mask, buf_we, buf_clr_hi;
    logic [CNT_W-1:0] rem, total, buf_idx;
    logic [DATA_W-1:0] buf_rd;
    logic cnt_wr, ctl_wr;

    assign cnt_wr = cpu_wr && cpu_addr == AW'(ADDR_CNT);
    assign ctl_wr = cpu_wr && cpu_addr == AW'(ADDR_CTL);

    dfm_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_wr     (cnt_wr),
        .cnt_bytes  (cpu_wdata),
        .ctl_wr     (ctl_wr),
        .ctl_mask   (cpu_wdata[0]),
        .ctl_clr    (cpu_wdata[1]),
        .dma_wr     (dma_wr),
        .dma_ack_n  (dma_ack_n),
        .busy       (busy),
        .irq        (irq),
        .mask       (mask),
        .rem        (rem),
        .total      (total),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .buf_clr_hi (buf_clr_hi)
    );

    dfm_wordbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .wr_idx  (buf_idx),
        .clr_hi  (buf_clr_hi),
        .wdata   (dma_wdata),
        .rd_idx  (CNT_W'(cpu_addr)),
        .rd_data (buf_rd)
    );

    assign dma_req = busy;

    always_comb begin
        cpu_rdata = '0;
        if (cpu_addr < AW'(DEPTH)) begin
            cpu_rdata = buf_rd;
        end else if (cpu_addr == AW'(ADDR_CNT)) begin
            cpu_rdata[CNT_W-1:0] = rem;
            cpu_rdata[8 +: CNT_W] = total;
        end else if (cpu_addr == AW'(ADDR_CTL)) begin
            cpu_rdata[2:0] = {busy, irq, mask};
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !dma_req && !irq); // R1
endmodule

// File: tb/dma_fill_mailbox_tb_top.sv
`timescale 1ns/1ps
module dma_fill_mailbox_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_wr = 1'b0;
    logic [3:0] cpu_addr = 4'd0;
    logic [15:0] cpu_wdata = 16'd0;
    logic [15:0] cpu_rdata;
    logic dma_req, irq;
    logic dma_ack_n = 1'b1;
    logic dma_wr = 1'b0;
    logic [15:0] dma_wdata = 16'd0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dma_fill_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dma_req(dma_req),
        .dma_ack_n(dma_ack_n), .dma_wr(dma_wr), .dma_wdata(dma_wdata), .irq(irq)
    );

    // behavioural reference
    int m_buf [$];
    int m_total, m_rem, m_busy, m_irq, m_mask, m_odd;

    task automatic model_reset();
        m_buf = {};
        for (int i = 0; i < 9; i++) m_buf.push_back(0);
        m_total = 0; m_rem = 0; m_busy = 0; m_irq = 0; m_mask = 0; m_odd = 0;
    endtask

    function automatic int model_read(int a);
        if (a < 9)  return m_buf[a];
        if (a == 9) return (m_total << 8) | m_rem;
        if (a == 10) return (m_busy << 2) | (m_irq << 1) | m_mask;
        return 0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int old_mask, done, go, w;
            old_mask = m_mask;
            done = 0;
            w = int'(cpu_wdata);
            go = cpu_wr && cpu_addr == 4'd9 && !m_busy && w >= 1 && w <= 18;
            if (m_busy && dma_wr && !dma_ack_n) begin
                int d;
                d = int'(dma_wdata);
                if (m_rem == 1 && m_odd) d = d % 256;
                m_buf[m_total - m_rem] = d;
                m_rem = m_rem - 1;
                if (m_rem == 0) begin m_busy = 0; done = 1; end
            end
            if (go) begin
                m_total = (w + 1) / 2; m_rem = m_total; m_odd = w % 2; m_busy = 1;
            end
            if (cpu_wr && cpu_addr == 4'd10) m_mask = w % 2;
            if (done && !old_mask) m_irq = 1;
            else if (go || (cpu_wr && cpu_addr == 4'd10 && ((w / 2) % 2) == 1)) m_irq = 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 dma_req vs model", int'(dma_req), m_busy);
            chk("R5 irq vs model", int'(irq), m_irq);
            chk("R12 cpu_rdata vs model", int'(cpu_rdata), model_read(int'(cpu_addr)));
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cpu_write(int a, int d);
        cpu_wr = 1'b1; cpu_addr = 4'(a); cpu_wdata = 16'(d);
        step();
        cpu_wr = 1'b0;
    endtask

    task automatic dma_put(int d, bit ack);
        dma_wr = 1'b1; dma_ack_n = !ack; dma_wdata = 16'(d);
        step();
        dma_wr = 1'b0; dma_ack_n = 1'b1;
    endtask

    task automatic peek(int a, string tag, int exp);
        cpu_addr = 4'(a);
        @(negedge clk);
        chk(tag, int'(cpu_rdata), exp);
        step();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        peek(9, "R1 count after reset", 0);
        peek(10, "R1 status after reset", 0);
        peek(4, "R1 buffer after reset", 0);
        chk("R1 dma_req after reset", int'(dma_req), 0);

        cpu_write(9, 5);
        peek(9, "R2 count for 5 bytes", 16'h0303);
        peek(10, "R2 busy set", 4);
        chk("R2 dma_req high", int'(dma_req), 1);
        dma_put(16'h1111, 0);
        peek(9, "R11 ack high discarded", 16'h0303);
        cpu_write(9, 4);
        peek(9, "R8 count write while busy", 16'h0303);
        dma_put(16'hA1B2, 1);
        peek(9, "R3 remaining decremented", 16'h0302);
        dma_put(16'hC3D4, 1);
        dma_put(16'hEEF5, 1);
        chk("R4 dma_req low after last", int'(dma_req), 0);
        peek(10, "R5 irq after completion", 2);
        peek(0, "R3 word 0", 16'hA1B2);
        peek(1, "R3 word 1", 16'hC3D4);
        peek(2, "R10 odd last word", 16'h00F5);
        peek(11, "R12 unmapped address", 0);
        cpu_write(10, 2);
        peek(10, "R5 irq cleared by clear bit", 0);

        cpu_write(9, 0);
        peek(10, "R7 zero count ignored", 0);
        cpu_write(9, 19);
        peek(10, "R9 oversize count no busy", 0);
        peek(9, "R9 oversize count register kept", 16'h0300);

        cpu_write(10, 1);
        dma_put(16'hBEEF, 1);
        peek(9, "R11 idle DMA write discarded", 16'h0300);
        cpu_write(9, 18);
        peek(9, "R2 count for 18 bytes", 16'h0909);
        for (int i = 0; i < 9; i++) dma_put(16'h0100 + i, 1);
        dma_put(16'hDEAD, 1);
        dma_put(16'hDEAD, 1);
        peek(10, "R6 masked completion no irq", 1);
        peek(8, "R11 overrun did not overwrite", 16'h0108);
        peek(0, "R3 word 0 refilled", 16'h0100);
        peek(9, "R4 remaining zero", 16'h0900);

        cpu_write(10, 0);
        cpu_write(9, 2);
        dma_put(16'h5A5A, 1);
        peek(10, "R5 irq even single word", 2);
        peek(0, "R10 even count keeps high byte", 16'h5A5A);
        cpu_write(9, 4);
        peek(10, "R5 irq cleared by new count", 4);
        dma_put(16'h1234, 1);
        dma_put(16'h5678, 1);
        peek(10, "R5 irq after second transfer", 2);
        peek(1, "R3 second word", 16'h5678);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule